// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake-Up Controller

This block switches a radio receiver on and off so that it draws little power. A mode input picks between two behaviours. With the mode input low, the reference oscillator and the frequency synthesizer are enabled all the time. With the mode input high, a free-running period timer starts a wake-up every `PERIOD_T` ticks. On each wake-up the oscillator comes on first. After a settling wait the synthesizer follows, and a short listening window opens.

During the listening window the controller watches a single-bit "signal strength above threshold" flag that comes from an external detector. If the flag is never seen, both enables drop when the window closes. If the flag is seen, the receiver stays on for an extended hold time. Every sync-word hit restarts that hold time. While packet decoding is still busy, the controller does not switch off.

All durations are counted in ticks of a slow enable pulse (`tick`), so the same block serves any time base. A threshold-select bit is passed straight through to the detector.

Top module: `rxw_wake_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `osc_en` and `synth_en` are low. All timers restart from zero after reset.
- R2: When `lp_mode` is sampled low on a clock edge, both enables are high from that edge on. This holds whatever the previous state was.
- R3: With `lp_mode` high and `tick` high every cycle, `osc_en` rises once every `PERIOD_T` ticks. It rises before `synth_en`, never in the same cycle.
- R4: `synth_en` rises exactly `SETTLE_T` ticks after `osc_en` rises, and it is never high while `osc_en` is low.
- R5: If `rssi_hit` is never sampled high during the `LISTEN_T`-tick window, both enables fall together when the window closes. The on time is then `SETTLE_T + LISTEN_T` ticks.
- R6: If `rssi_hit` is sampled high in any cycle of the window, the last one included, both enables stay high for a further `HOLD_T` ticks after the window closes.
- R7: A `sync_hit` pulse during the hold phase restarts the hold count from zero.
- R8: While `dec_busy` is high, `synth_en` is not switched off, even when the hold count has run out. Switch-off happens in the first cycle after `dec_busy` is sampled low.
- R9: A wake-up that falls while the receiver is still on is ignored. The period timer keeps its phase, so the next accepted wake-up comes at a multiple of `PERIOD_T` ticks after the previous one.
- R10: When `lp_mode` goes from low to high, both enables drop on the next edge. A fresh period starts then, and the first wake-up comes `PERIOD_T` ticks later.
- R11: `det_level` always equals `thr_sel`, in the same cycle.
- R12: While `tick` is low, no timer advances: a receiver that is off stays off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base enable pulse, one per tick |
| lp_mode | input | 1 | 1 = duty-cycled mode, 0 = continuously on |
| thr_sel | input | 1 | Detector threshold choice, forwarded unchanged |
| rssi_hit | input | 1 | Signal strength above the selected threshold |
| sync_hit | input | 1 | One-cycle pulse per detected sync word |
| dec_busy | input | 1 | Packet decoding in progress |
| det_level | output | 1 | Threshold choice sent to the detector |
| osc_en | output | 1 | Reference oscillator enable |
| synth_en | output | 1 | Frequency synthesizer enable |

## Verification
On every cycle the assertions check the following:
- the enables are low out of reset;
- continuous mode keeps both enables high;
- the synthesizer is never on without the oscillator, and it never rises in the same cycle as the oscillator in duty-cycled mode;
- a busy decoder keeps the synthesizer on.

Some behaviours depend on how long a phase lasts, and only the bench scenarios can show them. These are:
- the exact settle, listen and hold lengths;
- the restart of the hold count by a sync hit;
- the wake-up spacing, including a wake-up that is swallowed by a long busy period;
- the fresh period after a mode change;
- the stall while no ticks arrive.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_SETTLE = 3'd1,
      ST_LISTEN = 3'd2,
      ST_HOLD   = 3'd3,
      ST_CONT   = 3'd4
   } rxw_state_e;

   function automatic int rxw_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/rxw_period_timer.sv
module rxw_period_timer #(
   parameter int PERIOD_T = 300,
   parameter int PW       = $clog2(PERIOD_T + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic tick,
   output logic wake
);

   localparam logic [PW-1:0] LAST = PW'(PERIOD_T - 1);

   logic [PW-1:0] cnt_q;

   assign wake = run && tick && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/rxw_phase_counter.sv
module rxw_phase_counter #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         expire,
   output logic         held
);

   logic [W-1:0] cnt_q;
   logic         held_q;

   assign expire = tick && (cnt_q == (limit - 1'b1));
   assign held   = held_q;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q  <= '0;
         held_q <= 1'b0;
      end else begin
         if (expire) begin
            cnt_q  <= '0;
            held_q <= 1'b1;
         end else if (tick) begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rxw_fsm.sv
module rxw_fsm
   import rxw_pkg::*;
#(
   parameter int SETTLE_T = 2,
   parameter int LISTEN_T = 6,
   parameter int HOLD_T   = 31,
   parameter int W        = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         lp_mode,
   input  logic         wake,
   input  logic         rssi_hit,
   input  logic         sync_hit,
   input  logic         dec_busy,
   input  logic         expire,
   input  logic         held,
   output rxw_state_e   state,
   output logic         clr,
   output logic [W-1:0] limit
);

   rxw_state_e st_q, st_d;
   logic       hit_q, hit_d;
   logic       seen;

   assign seen = hit_q || rssi_hit;

   always_comb begin
      st_d  = st_q;
      hit_d = hit_q;
      if (!lp_mode) begin
         st_d = ST_CONT;
      end else begin
         unique case (st_q)
            ST_CONT:   st_d = ST_OFF;
            ST_OFF:    if (wake) st_d = ST_SETTLE;
            ST_SETTLE: if (expire) st_d = ST_LISTEN;
            ST_LISTEN: begin
               hit_d = seen;
               if (expire) st_d = (seen || dec_busy) ? ST_HOLD : ST_OFF;
            end
            ST_HOLD: begin
               if (!sync_hit && (expire || held) && !dec_busy) st_d = ST_OFF;
            end
            default:   st_d = ST_OFF;
         endcase
      end
      if (st_d != st_q) hit_d = 1'b0;
   end

   assign clr = (st_d != st_q) || ((st_q == ST_HOLD) && sync_hit);

   always_comb begin
      unique case (st_q)
         ST_SETTLE: limit = W'(SETTLE_T);
         ST_LISTEN: limit = W'(LISTEN_T);
         ST_HOLD:   limit = W'(HOLD_T);
         default:   limit = W'(1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_OFF;
         hit_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         hit_q <= hit_d;
      end
   end

   assign state = st_q;

endmodule

// File: rtl/rxw_wake_ctrl.sv
module rxw_wake_ctrl
   import rxw_pkg::*;
#(
   parameter int PERIOD_T = 300,
   parameter int SETTLE_T = 2,
   parameter int LISTEN_T = 6,
   parameter int HOLD_T   = 31,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic lp_mode,
   input  logic thr_sel,
   input  logic rssi_hit,
   input  logic sync_hit,
   input  logic dec_busy,
   output logic det_level,
   output logic osc_en,
   output logic synth_en
);

   localparam int PHASE_MAX = rxw_max3(SETTLE_T, LISTEN_T, HOLD_T);
   localparam int CW        = $clog2(PHASE_MAX + 1);
   localparam int PW        = $clog2(PERIOD_T + 1);

   if (SETTLE_T < 1 || LISTEN_T < 1 || HOLD_T < 1) begin : g_bad_phase
      $error("rxw_wake_ctrl: every phase must last at least one tick");
   end
   if (PERIOD_T <= SETTLE_T + LISTEN_T) begin : g_bad_period
      $error("rxw_wake_ctrl: period must exceed settle plus listen time");
   end

   logic          wake, expire, held, clr;
   logic [CW-1:0] limit;
   rxw_state_e    state;
   logic          osc_d, synth_d;

   rxw_period_timer #(.PERIOD_T(PERIOD_T), .PW(PW)) u_period (
      .clk  (clk),
      .rst  (rst),
      .run  (lp_mode),
      .tick (tick),
      .wake (wake)
   );

   rxw_phase_counter #(.W(CW)) u_phase (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .tick   (tick),
      .limit  (limit),
      .expire (expire),
      .held   (held)
   );

   rxw_fsm #(
      .SETTLE_T (SETTLE_T),
      .LISTEN_T (LISTEN_T),
      .HOLD_T   (HOLD_T),
      .W        (CW)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .lp_mode  (lp_mode),
      .wake     (wake),
      .rssi_hit (rssi_hit),
      .sync_hit (sync_hit),
      .dec_busy (dec_busy),
      .expire   (expire),
      .held     (held),
      .state    (state),
      .clr      (clr),
      .limit    (limit)
   );

   assign osc_d   = (state != ST_OFF);
   assign synth_d = (state == ST_LISTEN) || (state == ST_HOLD) || (state == ST_CONT);

   if (OUT_REG) begin : g_out_flop
      logic osc_q, synth_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            osc_q   <= 1'b0;
            synth_q <= 1'b0;
         end else begin
            osc_q   <= osc_d;
            synth_q <= synth_d;
         end
      end
      assign osc_en   = osc_q;
      assign synth_en = synth_q;
   end else begin : g_out_comb
      assign osc_en   = osc_d;
      assign synth_en = synth_d;
   end

   assign det_level = thr_sel;

endmodule

// File: rtl/rxw_wake_chk.sv
module rxw_wake_chk (
   input logic clk,
   input logic rst,
   input logic lp_mode,
   input logic dec_busy,
   input logic osc_en,
   input logic synth_en
);

   logic past_ok;

   always_ff @(posedge clk) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
   end

   assert_reset_off_R1: assert property (@(posedge clk)
      rst |=> (!osc_en && !synth_en));

   assert_cont_on_R2: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(lp_mode)) |-> (osc_en && synth_en));

   assert_osc_first_R3: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(lp_mode) && $rose(osc_en)) |-> !synth_en);

   assert_synth_needs_osc_R4: assert property (@(posedge clk) disable iff (rst)
      synth_en |-> osc_en);

   assert_busy_keeps_on_R8: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(lp_mode) && lp_mode && synth_en && dec_busy) |=> synth_en);

endmodule

bind rxw_wake_ctrl rxw_wake_chk u_wake_chk (
   .clk      (clk),
   .rst      (rst),
   .lp_mode  (lp_mode),
   .dec_busy (dec_busy),
   .osc_en   (osc_en),
   .synth_en (synth_en)
);

// File: tb/tb_rxw_wake_ctrl.sv
`timescale 1ns/1ps
module tb_rxw_wake_ctrl;

   localparam int P_T = 40;
   localparam int S_T = 3;
   localparam int L_T = 5;
   localparam int H_T = 8;

   // {hit index in window (-1 none), osc on cycles, synth on cycles, rise-to-rise gap}
   localparam int VEC [4][4] = '{
      '{-1, S_T + L_T,       L_T,       P_T},
      '{ 0, S_T + L_T + H_T, L_T + H_T, P_T},
      '{ 2, S_T + L_T + H_T, L_T + H_T, P_T},
      '{ 4, S_T + L_T + H_T, L_T + H_T, P_T}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b1;
   logic lp_mode = 1'b0;
   logic thr_sel = 1'b0;
   logic rssi_hit = 1'b0;
   logic sync_hit = 1'b0;
   logic dec_busy = 1'b0;
   logic det_level, osc_en, synth_en;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rxw_wake_ctrl #(
      .PERIOD_T (P_T),
      .SETTLE_T (S_T),
      .LISTEN_T (L_T),
      .HOLD_T   (H_T)
   ) dut (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .lp_mode   (lp_mode),
      .thr_sel   (thr_sel),
      .rssi_hit  (rssi_hit),
      .sync_hit  (sync_hit),
      .dec_busy  (dec_busy),
      .det_level (det_level),
      .osc_en    (osc_en),
      .synth_en  (synth_en)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic observe(input int hit_at, input int sync_at, input int busy_at,
                          input int busy_len, output int osc_n, output int syn_n,
                          output int rise_at);
      osc_n = 0;
      syn_n = 0;
      @(negedge clk);
      while (osc_en !== 1'b1) @(negedge clk);
      rise_at = cyc;
      while (osc_en === 1'b1) begin
         osc_n++;
         if (synth_en === 1'b1) begin
            rssi_hit = (syn_n == hit_at);
            sync_hit = (syn_n == sync_at);
            if (syn_n == busy_at) dec_busy = 1'b1;
            if (syn_n == busy_at + busy_len) dec_busy = 1'b0;
            syn_n++;
         end else begin
            rssi_hit = 1'b0;
            sync_hit = 1'b0;
         end
         @(negedge clk);
      end
      rssi_hit = 1'b0;
      sync_hit = 1'b0;
      dec_busy = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int osc_n, syn_n, rise, prev_rise, c0;
      bit saw_on;

      repeat (3) @(negedge clk);
      chk("R1 osc_en in reset", int'(osc_en), 0);
      chk("R1 synth_en in reset", int'(synth_en), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R2 osc_en continuous", int'(osc_en), 1);
      chk("R2 synth_en continuous", int'(synth_en), 1);

      thr_sel = 1'b1;
      #1 chk("R11 det_level high", int'(det_level), 1);
      thr_sel = 1'b0;
      #1 chk("R11 det_level low", int'(det_level), 0);

      // R10: low-to-high mode change starts a fresh period
      @(negedge clk);
      lp_mode = 1'b1;
      c0 = cyc;
      @(negedge clk);
      chk("R10 osc_en off after mode rise", int'(osc_en), 0);
      chk("R10 synth_en off after mode rise", int'(synth_en), 0);
      observe(-1, -1, -1, 0, osc_n, syn_n, rise);
      chk("R10 first wake delay", rise - c0, P_T);
      prev_rise = rise;

      // vector table: window hits at several positions
      for (int i = 0; i < 4; i++) begin
         observe(VEC[i][0], -1, -1, 0, osc_n, syn_n, rise);
         chk((VEC[i][0] < 0) ? "R5 osc on time" : "R6 osc on time", osc_n, VEC[i][1]);
         chk((VEC[i][0] < 0) ? "R5 synth on time" : "R6 synth on time", syn_n, VEC[i][2]);
         chk("R4 settle before synth", osc_n - syn_n, S_T);
         chk("R3 wake spacing", rise - prev_rise, VEC[i][3]);
         prev_rise = rise;
      end

      // R7: sync hit in hold restarts the hold count
      observe(0, L_T + 4, -1, 0, osc_n, syn_n, rise);
      chk("R7 synth on time with sync restart", syn_n, L_T + 4 + 1 + H_T);
      prev_rise = rise;

      // R8: busy defers switch-off past hold expiry
      observe(0, -1, 10, 10, osc_n, syn_n, rise);
      chk("R8 synth held while busy", syn_n, 21);
      chk("R3 wake spacing before busy", rise - prev_rise, P_T);
      prev_rise = rise;

      // R9: long busy swallows a wake-up, phase kept
      observe(0, -1, 10, 40, osc_n, syn_n, rise);
      chk("R8 synth held long busy", syn_n, 51);
      prev_rise = rise;
      observe(-1, -1, -1, 0, osc_n, syn_n, rise);
      chk("R9 swallowed wake spacing", rise - prev_rise, 2 * P_T);

      // R12: no ticks, no wake-up
      @(negedge clk);
      lp_mode = 1'b0;
      repeat (2) @(negedge clk);
      lp_mode = 1'b1;
      tick = 1'b0;
      saw_on = 1'b0;
      repeat (3 * P_T) begin
         @(negedge clk);
         if (osc_en !== 1'b0) saw_on = 1'b1;
      end
      chk("R12 off while no ticks", int'(saw_on), 0);
      tick = 1'b1;
      c0 = cyc;
      observe(-1, -1, -1, 0, osc_n, syn_n, rise);
      chk("R12 wake after ticks resume", rise - c0, P_T);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule